// File: doc/BRIEF.md
# HDQ Single-Wire Bus Master Sequencer

This block runs the master side of a single-wire battery-gauge bus. One open-drain line carries all traffic. An external pull-up holds the line high, and the block only ever pulls it low. All timing is counted in periods of a sample tick. The `TICK_US` parameter gives the tick period in microseconds, and every duration is loaded into a counter as that duration divided by the tick period.

A transaction starts when the request counter input differs from the completed counter output. The block first sends a break: the line is held low, then released for a recovery gap. Next it sends a command byte, least-significant bit first. The low seven bits of the command byte are the register address and bit 7 is the direction.

Each bit takes a fixed-length cell, and the length of the low phase inside the cell carries the bit value. A write then sends the data byte, with a quiet gap after each byte. A read releases the line and waits for the slave to pull it low. When the slave does so, a one-cycle pulse hands control to a separate receive decoder. If the wait times out, the transaction ends with an error code.

Top module: `hdq_master`

## Requirements
- R1: After synchronous reset: `busy` is 0, `line_oe` is 0, `done` is 0, `rx_start` is 0, `done_ctr` is 0 and `err_code` is 0.
- R2: A request is accepted on a tick while idle and `req_ctr != done_ctr`. From that tick on, `busy` is 1 and the line is pulled low (`line_oe` = 1) for 250/TICK_US ticks of break.
- R3: After the break, the line is released (`line_oe` = 0) for 60/TICK_US ticks before the first bit.
- R4: The command byte sent has `req_write` in bit 7 (1 = write, 0 = read) and `req_addr` in bits 6..0. It is sent least-significant bit first.
- R5: Every transmitted bit takes 210/TICK_US ticks. A 1 is pulled low for 50/TICK_US ticks and a 0 for 120/TICK_US ticks, and the line is released for the rest of the cell.
- R6: A write sends the command byte, a 300/TICK_US-tick released gap, the `req_wdata` byte (LSB first), and another gap of the same length. The transaction then ends with `err_code` 0.
- R7: A read releases the line after the command byte and checks `line_in` on each tick for up to 2500/TICK_US ticks. A low seen on any of those ticks, including the last, pulses `rx_start` and ends the transaction with `err_code` 0.
- R8: If a read sees no low within the listen window, it ends on the last tick of the window with `err_code` 1 and no `rx_start`.
- R9: On completion, `done` pulses for one cycle, `busy` falls, and `done_ctr` takes the value `req_ctr` has at that moment. This happens whatever the error code.
- R10: Requests and operand changes that arrive while busy are ignored. The waveform uses the operands latched at acceptance, and no new transaction starts after completion.
- R11: `line_oe` changes only in a cycle that follows a tick. While idle the line is never pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle sample tick, period TICK_US microseconds |
| req_ctr | input | CNT_W | Request counter; a new value starts a transaction |
| req_addr | input | 7 | Register address for the command byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Byte sent by a write |
| line_in | input | 1 | Sensed bus level (asynchronous) |
| line_oe | output | 1 | Pull-low enable for the open-drain driver |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| done_ctr | output | CNT_W | Completed-transaction counter |
| err_code | output | 2 | 0 = no error, 1 = read got no response |
| rx_start | output | 1 | One-cycle handoff pulse to the receive decoder |

## Verification
Assertions check on every cycle that the pull-low enable moves only after a tick, that the line stays released while idle, and that a pending request is taken on the next idle tick. They also check that completion copies the request counter, that a handoff never comes with an error, and that every counter load is non-zero. Only the bench scenarios can show the exact waveform, tick by tick. That covers break, recovery, bit order and the low-phase lengths of both bit values, for a sweep of addresses and data bytes. The scenarios also cover the listen-window edges: a response on the very last tick, and a timeout one tick after it. Finally they show that a request raised mid-transaction is dropped.

// File: rtl/hdq_pkg.sv
package hdq_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    // bus durations in microseconds
    localparam int US_BREAK    = 250;
    localparam int US_RECOVER  = 60;
    localparam int US_ONE_LOW  = 50;
    localparam int US_ZERO_LOW = 120;
    localparam int US_CELL     = 210;
    localparam int US_GAP      = 300;
    localparam int US_LISTEN   = 2500;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BREAK,
        ST_RECOVER,
        ST_BIT_LOW,
        ST_BIT_HIGH,
        ST_GAP,
        ST_LISTEN
    } seq_state_t;

    typedef enum logic [1:0] {
        ERR_NONE        = 2'd0,
        ERR_NO_RESPONSE = 2'd1
    } err_t;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    function automatic int to_ticks(input int us, input int tick_us);
        int t;
        t = us / tick_us;
        return (t < 1) ? 1 : t;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hdq_line_sync.sv
module hdq_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= din;
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/hdq_phase_timer.sv
module hdq_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (load)             cnt <= load_val;
        else if (tick && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign expire = tick && (cnt == W'(1));

    // R5: a phase never gets a zero length
    a_r5_load_nonzero: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));
endmodule

// File: rtl/hdq_bit_shifter.sv
module hdq_bit_shifter #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_take,
    input  logic         take,
    input  logic [W-1:0] din,
    output logic         bit_out,
    output logic         more
);
    logic [W-1:0]  sh;
    logic [CW-1:0] left;

    // loading and consuming bit 0 happen in the same cycle
    assign bit_out = load_take ? din[0] : sh[0];
    assign more    = (left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            left <= '0;
        end else if (load_take) begin
            sh   <= din >> 1;
            left <= CW'(W - 1);
        end else if (take) begin
            sh   <= sh >> 1;
            left <= left - 1'b1;
        end
    end

    // R4: never consume more bits than were loaded
    a_r4_take_only_when_more: assert property (@(posedge clk) disable iff (rst)
        take |-> more);
endmodule

// File: rtl/hdq_master.sv
module hdq_master #(
    parameter int TICK_US     = 10,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    input  logic [CNT_W-1:0]         req_ctr,
    input  logic [hdq_pkg::ADDR_W-1:0] req_addr,
    input  logic                     req_write,
    input  logic [hdq_pkg::BYTE_W-1:0] req_wdata,
    input  logic                     line_in,
    output logic                     line_oe,
    output logic                     busy,
    output logic                     done,
    output logic [CNT_W-1:0]         done_ctr,
    output logic [1:0]               err_code,
    output logic                     rx_start
);
    import hdq_pkg::*;

    localparam int T_BREAK  = to_ticks(US_BREAK, TICK_US);
    localparam int T_REC    = to_ticks(US_RECOVER, TICK_US);
    localparam int T_ONE    = to_ticks(US_ONE_LOW, TICK_US);
    localparam int T_ZERO   = to_ticks(US_ZERO_LOW, TICK_US);
    localparam int T_CELL   = to_ticks(US_CELL, TICK_US);
    localparam int T_GAP    = to_ticks(US_GAP, TICK_US);
    localparam int T_LISTEN = to_ticks(US_LISTEN, TICK_US);
    localparam int T_MAX    = max2(max2(max2(T_BREAK, T_REC), max2(T_CELL, T_GAP)), T_LISTEN);
    localparam int TW       = $clog2(T_MAX + 1);

    localparam logic [TW-1:0] L_BREAK  = TW'(T_BREAK);
    localparam logic [TW-1:0] L_REC    = TW'(T_REC);
    localparam logic [TW-1:0] L_ONE    = TW'(T_ONE);
    localparam logic [TW-1:0] L_ZERO   = TW'(T_ZERO);
    localparam logic [TW-1:0] L_CELL   = TW'(T_CELL);
    localparam logic [TW-1:0] L_GAP    = TW'(T_GAP);
    localparam logic [TW-1:0] L_LISTEN = TW'(T_LISTEN);

    seq_state_t st, st_nxt;
    cmd_t               cmd_q;
    logic [BYTE_W-1:0]  wdata_q;
    logic               data_q, data_nxt;
    logic [TW-1:0]      hi_q;
    logic               oe_nxt;
    err_t               err_q, fin_code;
    logic               fin, rx_go, accept;

    logic               t_load, t_exp;
    logic [TW-1:0]      t_val;
    logic               sh_lt, sh_take, sh_bit, sh_more;
    logic [BYTE_W-1:0]  sh_din;
    logic               line_s;

    hdq_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (line_in),
        .dout(line_s)
    );

    hdq_phase_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .load    (t_load),
        .load_val(t_val),
        .expire  (t_exp)
    );

    hdq_bit_shifter #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load_take(sh_lt),
        .take     (sh_take),
        .din      (sh_din),
        .bit_out  (sh_bit),
        .more     (sh_more)
    );

    always_comb begin
        st_nxt   = st;
        oe_nxt   = line_oe;
        data_nxt = data_q;
        t_load   = 1'b0;
        t_val    = '0;
        sh_lt    = 1'b0;
        sh_take  = 1'b0;
        sh_din   = cmd_q;
        fin      = 1'b0;
        fin_code = ERR_NONE;
        rx_go    = 1'b0;
        accept   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (tick && (req_ctr != done_ctr)) begin
                    accept = 1'b1;
                    st_nxt = ST_BREAK;
                    oe_nxt = 1'b1;
                    t_load = 1'b1;
                    t_val  = L_BREAK;
                end
            end
            ST_BREAK: begin
                if (t_exp) begin
                    st_nxt = ST_RECOVER;
                    oe_nxt = 1'b0;
                    t_load = 1'b1;
                    t_val  = L_REC;
                end
            end
            ST_RECOVER: begin
                if (t_exp) begin
                    sh_lt  = 1'b1;
                    sh_din = cmd_q;
                    st_nxt = ST_BIT_LOW;
                    oe_nxt = 1'b1;
                    t_load = 1'b1;
                    t_val  = sh_bit ? L_ONE : L_ZERO;
                end
            end
            ST_BIT_LOW: begin
                if (t_exp) begin
                    st_nxt = ST_BIT_HIGH;
                    oe_nxt = 1'b0;
                    t_load = 1'b1;
                    t_val  = hi_q;
                end
            end
            ST_BIT_HIGH: begin
                if (t_exp) begin
                    t_load = 1'b1;
                    if (sh_more) begin
                        sh_take = 1'b1;
                        st_nxt  = ST_BIT_LOW;
                        oe_nxt  = 1'b1;
                        t_val   = sh_bit ? L_ONE : L_ZERO;
                    end else if (cmd_q.write) begin
                        st_nxt = ST_GAP;
                        t_val  = L_GAP;
                    end else begin
                        st_nxt = ST_LISTEN;
                        t_val  = L_LISTEN;
                    end
                end
            end
            ST_GAP: begin
                if (t_exp) begin
                    if (!data_q) begin
                        data_nxt = 1'b1;
                        sh_lt    = 1'b1;
                        sh_din   = wdata_q;
                        st_nxt   = ST_BIT_LOW;
                        oe_nxt   = 1'b1;
                        t_load   = 1'b1;
                        t_val    = sh_bit ? L_ONE : L_ZERO;
                    end else begin
                        fin = 1'b1;
                    end
                end
            end
            ST_LISTEN: begin
                if (tick) begin
                    if (!line_s) begin
                        rx_go = 1'b1;
                        fin   = 1'b1;
                    end else if (t_exp) begin
                        fin      = 1'b1;
                        fin_code = ERR_NO_RESPONSE;
                    end
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
        if (fin) begin
            st_nxt = ST_IDLE;
            oe_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            line_oe  <= 1'b0;
            done     <= 1'b0;
            rx_start <= 1'b0;
            done_ctr <= '0;
            err_q    <= ERR_NONE;
            cmd_q    <= '0;
            wdata_q  <= '0;
            data_q   <= 1'b0;
            hi_q     <= '0;
        end else begin
            st       <= st_nxt;
            line_oe  <= oe_nxt;
            done     <= fin;
            rx_start <= rx_go;
            data_q   <= data_nxt;
            if (st_nxt == ST_BIT_LOW && st != ST_BIT_LOW)
                hi_q <= L_CELL - t_val;
            if (accept) begin
                cmd_q   <= '{write: req_write, addr: req_addr};
                wdata_q <= req_wdata;
                data_q  <= 1'b0;
            end
            if (fin) begin
                done_ctr <= req_ctr;
                err_q    <= fin_code;
            end
        end
    end

    assign busy     = (st != ST_IDLE);
    assign err_code = err_q;

    // R11: the pull-low enable moves only on tick boundaries
    a_r11_oe_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> $stable(line_oe));

    // R11: idle never pulls the line
    a_r11_idle_released: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !line_oe);

    // R2: a pending request is taken on the next idle tick, starting the break
    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        (tick && !busy && (req_ctr != done_ctr)) |=> (busy && line_oe));

    // R9: completion copies the request count
    a_r9_done_copies: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_ctr == $past(req_ctr)));

    // R9: busy only falls together with the completion pulse
    a_r9_busy_falls_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R7: handoff always comes with a clean completion
    a_r7_handoff_clean: assert property (@(posedge clk) disable iff (rst)
        rx_start |-> (done && err_code == 2'd0));
endmodule

// File: tb/hdq_master_test.sv
module hdq_master_test;
    localparam int CLK_NS    = 10;
    localparam int TICK_CLKS = 4;
    localparam int TICK_US   = 10;
    localparam int CNT_W     = 4;
    localparam int LIMIT     = 190000;

    localparam int N_BREAK  = 250 / TICK_US;
    localparam int N_REC    = 60 / TICK_US;
    localparam int N_ONE    = 50 / TICK_US;
    localparam int N_ZERO   = 120 / TICK_US;
    localparam int N_CELL   = 210 / TICK_US;
    localparam int N_GAP    = 300 / TICK_US;
    localparam int N_LISTEN = 2500 / TICK_US;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic [CNT_W-1:0] req_ctr = '0;
    logic [6:0] req_addr = '0;
    logic req_write = 1'b0;
    logic [7:0] req_wdata = '0;
    logic slave_low = 1'b0;
    logic line_in;
    logic line_oe, busy, done, rx_start;
    logic [CNT_W-1:0] done_ctr;
    logic [1:0] err_code;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    logic exp_oe [0:1023];
    int   exp_n;

    always #(CLK_NS/2) clk = ~clk;

    assign line_in = !(line_oe || slave_low);

    hdq_master #(.TICK_US(TICK_US), .CNT_W(CNT_W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .tick(tick), .req_ctr(req_ctr),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .line_in(line_in), .line_oe(line_oe), .busy(busy), .done(done),
        .done_ctr(done_ctr), .err_code(err_code), .rx_start(rx_start)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic do_tick();
        repeat (TICK_CLKS - 1) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic push(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            exp_oe[exp_n] = v;
            exp_n++;
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            int lo;
            lo = b[i] ? N_ONE : N_ZERO;
            push(1'b1, lo);
            push(1'b0, N_CELL - lo);
        end
    endtask

    task automatic build(input logic wr, input logic [6:0] a, input logic [7:0] d);
        exp_n = 0;
        push(1'b1, N_BREAK);
        push(1'b0, N_REC);
        push_byte({wr, a});
        if (wr) begin
            push(1'b0, N_GAP);
            push_byte(d);
            push(1'b0, N_GAP);
        end
    endtask

    // R2 R3 R4 R5 R6 R9 R10
    task automatic run_write(input logic [6:0] a, input logic [7:0] d, input bit bump);
        int mism;
        mism = 0;
        req_addr  = a;
        req_write = 1'b1;
        req_wdata = d;
        req_ctr   = req_ctr + 1'b1;
        build(1'b1, a, d);
        for (int k = 0; k < exp_n; k++) begin
            do_tick();
            if (k == 0) chk(busy === 1'b1, "R2 busy after accept", busy, 1);
            if (line_oe !== exp_oe[k]) mism++;
            if (bump && k == 100) begin
                req_ctr   = req_ctr + 1'b1;
                req_addr  = ~a;
                req_write = 1'b0;
                req_wdata = ~d;
            end
        end
        chk(mism == 0, "R3/R4/R5/R6 write waveform mismatches", mism, 0);
        do_tick();
        chk(done === 1'b1, "R9 done pulse", done, 1);
        chk(busy === 1'b0, "R9 busy falls", busy, 0);
        chk(done_ctr === req_ctr, "R9 done_ctr copies req_ctr", done_ctr, req_ctr);
        chk(err_code === 2'd0, "R6 write error code", err_code, 0);
        chk(line_oe === 1'b0, "R11 released at end", line_oe, 0);
        @(negedge clk);
        chk(done === 1'b0, "R9 done is one cycle", done, 0);
        if (bump) begin
            int stray;
            stray = 0;
            for (int k = 0; k < 20; k++) begin
                do_tick();
                if (busy !== 1'b0 || line_oe !== 1'b0) stray++;
            end
            chk(stray == 0, "R10 mid-transaction request dropped", stray, 0);
        end
    endtask

    // R7 R8: resp_at < 0 means the slave never answers
    task automatic run_read(input logic [6:0] a, input int resp_at);
        int mism, win;
        logic e;
        mism = 0;
        req_addr  = a;
        req_write = 1'b0;
        req_wdata = 8'hC3;
        req_ctr   = req_ctr + 1'b1;
        build(1'b0, a, 8'h00);
        win = (resp_at < 0) ? (exp_n + N_LISTEN) : (resp_at + 1);
        for (int k = 0; k < win; k++) begin
            do_tick();
            e = (k < exp_n) ? exp_oe[k] : 1'b0;
            if (line_oe !== e) mism++;
            if (k >= exp_n && busy !== 1'b1) mism++;
            if (k == resp_at) slave_low = 1'b1;
        end
        chk(mism == 0, "R4/R5/R7 read waveform mismatches", mism, 0);
        do_tick();
        chk(done === 1'b1, "R9 read done pulse", done, 1);
        chk(busy === 1'b0, "R9 read busy falls", busy, 0);
        chk(done_ctr === req_ctr, "R9 read done_ctr", done_ctr, req_ctr);
        if (resp_at < 0) begin
            chk(err_code === 2'd1, "R8 timeout error code", err_code, 1);
            chk(rx_start === 1'b0, "R8 no handoff on timeout", rx_start, 0);
        end else begin
            chk(err_code === 2'd0, "R7 response error code", err_code, 0);
            chk(rx_start === 1'b1, "R7 handoff pulse", rx_start, 1);
        end
        slave_low = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [6:0] addrs [0:4];
        logic [7:0] datas [0:3];
        addrs[0] = 7'h00; addrs[1] = 7'h01; addrs[2] = 7'h55;
        addrs[3] = 7'h2A; addrs[4] = 7'h7F;
        datas[0] = 8'h00; datas[1] = 8'hFF; datas[2] = 8'hA5; datas[3] = 8'h3C;

        repeat (5) @(negedge clk);
        // R1 reset values
        chk(busy === 1'b0, "R1 busy", busy, 0);
        chk(line_oe === 1'b0, "R1 line_oe", line_oe, 0);
        chk(done === 1'b0 && rx_start === 1'b0, "R1 pulses", done, 0);
        chk(done_ctr === '0, "R1 done_ctr", done_ctr, 0);
        chk(err_code === 2'd0, "R1 err_code", err_code, 0);
        rst = 1'b0;

        // R11 no request: nothing happens across ticks
        begin
            int act;
            act = 0;
            for (int k = 0; k < 10; k++) begin
                do_tick();
                if (busy !== 1'b0 || line_oe !== 1'b0) act++;
            end
            chk(act == 0, "R11 idle without request", act, 0);
        end

        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 4; j++)
                run_write(addrs[i], datas[j], 1'b0);

        run_read(7'h00, N_LISTEN + 199 - 250);
        run_read(7'h7F, 230);
        run_read(7'h55, 447);
        run_read(7'h2A, 448);
        run_read(7'h01, -1);
        // the error clears on the next good transaction
        run_write(7'h33, 8'h81, 1'b0);
        run_read(7'h4C, -1);

        // R10 request and operand changes during a write
        run_write(7'h12, 8'h6E, 1'b1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > LIMIT && !finished) begin
                bad++;
                total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end
endmodule